// File: doc/BRIEF.md
# Speculative Load Tracking Queue with Miss Replay

This block follows every load of an out-of-order core from the moment its address is generated until the reorder buffer retires it. When a load enters the load/store pipeline, the block gives it a slot and stores four things: the effective address, the access size, the signedness and the reorder-buffer tag. The execute stage later reports the cache result for that slot. A hit means the load is finished. A miss means the load waits. It waits either on a particular miss-queue entry or, if the miss queue had no room, until the miss queue reports a free entry.

A load that is ready to go again is offered back to the head of the load/store pipeline. At most one load is offered per cycle, and the oldest ready load by allocation order goes first. When a store retires, it presents its address and size. Every queued load whose bytes overlap that store is flagged as mis-speculated. When the flagged load retires, the block reports the flag so that the core can flush and restart at that load. A flush empties the queue in one cycle.

Top module: `ld_queue`

## Requirements
- R1: An allocation takes the lowest-numbered free slot, which is shown on `alloc_idx_o`. It records the address, size, signedness and reorder tag. When every slot is occupied, `alloc_ready_o` is low and no slot is taken.
- R2: An update on a waiting slot with `upd_hit_i` high completes the load, and the load is never offered for replay.
- R3: An update with a miss that was neither full nor line-ready stores `upd_mq_tag_i`. The load becomes replayable on the cycle after a `fill_valid_i` whose `fill_tag_i` equals the stored tag. This also holds when the update and the matching fill arrive in the same cycle. A fill with a different tag has no effect.
- R4: An update with a miss and `upd_mq_full_i` high puts the load to sleep. It becomes replayable only after a `mq_free_i` pulse.
- R5: An update with a miss and `upd_line_rdy_i` high makes the load replayable on the next cycle, with no wake needed.
- R6: At most one slot is offered per cycle on `rpl_valid_o`/`rpl_idx_o`, and it is the oldest replayable slot by allocation order, not by index. The outputs show that slot's address, size, signedness and tag. When `rpl_ready_i` accepts it, the slot returns to waiting for an update.
- R7: A store check flags each valid load that lies in the same 4-byte word and whose byte mask overlaps the store's byte mask. Size codes are 0 = byte, 1 = half, 2 = word. A byte covers mask bit addr[1:0]. A half covers bits {addr[1],0} and {addr[1],1}. A word covers all four bits.
- R8: A retire frees the slot. `ret_misspec_o` is high in the retire cycle exactly when that slot was flagged.
- R9: `flush_i` empties every slot in one cycle, and an allocation presented in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Pipeline flush |
| alloc_valid_i | input | 1 | New load request |
| alloc_addr_i | input | ADDR_W | Effective address |
| alloc_size_i | input | 2 | Access size code |
| alloc_uns_i | input | 1 | Zero-extend load |
| alloc_rob_i | input | ROB_W | Destination reorder tag |
| alloc_ready_o | output | 1 | A slot is free |
| alloc_idx_o | output | IDX_W | Slot that would be taken |
| upd_valid_i | input | 1 | Execute result valid |
| upd_idx_i | input | IDX_W | Slot of the result |
| upd_hit_i | input | 1 | Cache hit |
| upd_mq_full_i | input | 1 | Miss queue refused |
| upd_line_rdy_i | input | 1 | Line already complete, fill ready |
| upd_mq_tag_i | input | MQ_W | Miss-queue entry assigned |
| fill_valid_i | input | 1 | Line arrived broadcast |
| fill_tag_i | input | MQ_W | Miss-queue entry of the line |
| mq_free_i | input | 1 | Miss queue has room |
| rpl_valid_o | output | 1 | Replay offered |
| rpl_ready_i | input | 1 | Pipeline takes the replay |
| rpl_idx_o | output | IDX_W | Replayed slot |
| rpl_addr_o | output | ADDR_W | Replay address |
| rpl_size_o | output | 2 | Replay size code |
| rpl_uns_o | output | 1 | Replay signedness |
| rpl_rob_o | output | ROB_W | Replay reorder tag |
| st_valid_i | input | 1 | Retiring store check |
| st_addr_i | input | ADDR_W | Store address |
| st_size_i | input | 2 | Store size code |
| ret_valid_i | input | 1 | Load retires |
| ret_idx_i | input | IDX_W | Retiring slot |
| ret_misspec_o | output | 1 | Retiring load was flagged |

## Verification
Corrupt age ordering would appear on `rpl_idx_o` as soon as two slots are ready together. For that reason, the bench frees and reallocates a low slot so that index order and age order disagree. A wrong sleep or wake state would show up on the replay port within one cycle of the fill or free pulse, either as a missing offer or as a spurious one. A mis-set overlap flag would show only at retirement, so the bench crosses every aligned load size and offset with every store size and offset, both inside and outside the word, and retires after each check.

// File: rtl/ld_queue_pkg.sv
package ld_queue_pkg;
  typedef enum logic [2:0] {
    LS_EXEC,
    LS_WAIT_TAG,
    LS_WAIT_FREE,
    LS_READY,
    LS_DONE
  } ld_state_e;

  // size code: 0 byte, 1 half, 2 word
  function automatic logic [3:0] byte_span(input logic [1:0] lo, input logic [1:0] sz);
    case (sz)
      2'd0:    return 4'b0001 << lo;
      2'd1:    return lo[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/ld_free_pick.sv
module ld_free_pick #(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] valid_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ld_age_matrix.sv
module ld_age_matrix #(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_fire_i,
  input  logic [IDX_W-1:0] alloc_idx_i,
  input  logic [DEPTH-1:0] req_i,
  output logic [DEPTH-1:0] gnt_o
);
  // older_q[j][i] set: slot j was allocated before slot i
  logic [DEPTH-1:0] older_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < DEPTH; j++) older_q[j] <= '0;
    end else if (alloc_fire_i) begin
      for (int j = 0; j < DEPTH; j++) older_q[j][alloc_idx_i] <= (j != int'(alloc_idx_i));
      older_q[alloc_idx_i] <= '0;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_col
    logic [DEPTH-1:0] col;
    for (genvar j = 0; j < DEPTH; j++) begin : g_bit
      assign col[j] = older_q[j][i];
    end
    assign gnt_o[i] = req_i[i] && !(|(req_i & col));
  end
endmodule

// File: rtl/ld_overlap.sv
module ld_overlap
  import ld_queue_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] ld_addr_i [DEPTH],
  input  logic [1:0]        ld_size_i [DEPTH],
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [1:0]        st_size_i,
  output logic [DEPTH-1:0]  hit_o
);
  logic [3:0] st_mask;
  assign st_mask = byte_span(st_addr_i[1:0], st_size_i);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [3:0] ld_mask;
    logic       same_word;
    assign ld_mask   = byte_span(ld_addr_i[i][1:0], ld_size_i[i]);
    assign same_word = ld_addr_i[i][ADDR_W-1:2] == st_addr_i[ADDR_W-1:2];
    assign hit_o[i]  = same_word && |(ld_mask & st_mask);
  end
endmodule

// File: rtl/ld_queue.sv
module ld_queue
  import ld_queue_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int ROB_W  = 5,
  parameter int MQ_W   = 2,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              alloc_valid_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic [1:0]        alloc_size_i,
  input  logic              alloc_uns_i,
  input  logic [ROB_W-1:0]  alloc_rob_i,
  output logic              alloc_ready_o,
  output logic [IDX_W-1:0]  alloc_idx_o,
  input  logic              upd_valid_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  logic              upd_hit_i,
  input  logic              upd_mq_full_i,
  input  logic              upd_line_rdy_i,
  input  logic [MQ_W-1:0]   upd_mq_tag_i,
  input  logic              fill_valid_i,
  input  logic [MQ_W-1:0]   fill_tag_i,
  input  logic              mq_free_i,
  output logic              rpl_valid_o,
  input  logic              rpl_ready_i,
  output logic [IDX_W-1:0]  rpl_idx_o,
  output logic [ADDR_W-1:0] rpl_addr_o,
  output logic [1:0]        rpl_size_o,
  output logic              rpl_uns_o,
  output logic [ROB_W-1:0]  rpl_rob_o,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [1:0]        st_size_i,
  input  logic              ret_valid_i,
  input  logic [IDX_W-1:0]  ret_idx_i,
  output logic              ret_misspec_o
);
  logic [DEPTH-1:0]  valid_q;
  logic [DEPTH-1:0]  mis_q;
  logic [DEPTH-1:0]  ready_vec;
  logic [DEPTH-1:0]  gnt;
  logic [DEPTH-1:0]  st_hit;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [1:0]        size_q [DEPTH];
  logic              uns_q  [DEPTH];
  logic [ROB_W-1:0]  rob_q  [DEPTH];
  logic [MQ_W-1:0]   tag_q  [DEPTH];
  ld_state_e         st_q   [DEPTH];

  logic free_found;
  logic alloc_fire;

  ld_free_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_free (
    .valid_i (valid_q),
    .found_o (free_found),
    .idx_o   (alloc_idx_o)
  );

  assign alloc_ready_o = free_found;
  assign alloc_fire    = alloc_valid_i && free_found && !flush_i;

  ld_age_matrix #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_age (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_fire_i (alloc_fire),
    .alloc_idx_i  (alloc_idx_o),
    .req_i        (ready_vec),
    .gnt_o        (gnt)
  );

  ld_overlap #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ovl (
    .ld_addr_i (addr_q),
    .ld_size_i (size_q),
    .st_addr_i (st_addr_i),
    .st_size_i (st_size_i),
    .hit_o     (st_hit)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic alloc_me, upd_me, ret_me, rpl_me, wake_tag;
    assign alloc_me = alloc_fire && (alloc_idx_o == IDX_W'(i));
    assign upd_me   = upd_valid_i && (upd_idx_i == IDX_W'(i)) && st_q[i] == LS_EXEC;
    assign ret_me   = ret_valid_i && (ret_idx_i == IDX_W'(i));
    assign rpl_me   = gnt[i] && rpl_ready_i;
    assign wake_tag = fill_valid_i && (fill_tag_i == tag_q[i]);
    assign ready_vec[i] = valid_q[i] && st_q[i] == LS_READY;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        mis_q[i]   <= 1'b0;
        addr_q[i]  <= '0;
        size_q[i]  <= '0;
        uns_q[i]   <= 1'b0;
        rob_q[i]   <= '0;
        tag_q[i]   <= '0;
        st_q[i]    <= LS_DONE;
      end else if (flush_i) begin
        valid_q[i] <= 1'b0;
      end else if (alloc_me) begin
        valid_q[i] <= 1'b1;
        mis_q[i]   <= 1'b0;
        addr_q[i]  <= alloc_addr_i;
        size_q[i]  <= alloc_size_i;
        uns_q[i]   <= alloc_uns_i;
        rob_q[i]   <= alloc_rob_i;
        st_q[i]    <= LS_EXEC;
      end else if (valid_q[i]) begin
        if (ret_me) valid_q[i] <= 1'b0;
        if (st_valid_i && st_hit[i]) mis_q[i] <= 1'b1;
        case (st_q[i])
          LS_EXEC: begin
            if (upd_me) begin
              if (upd_hit_i)           st_q[i] <= LS_DONE;
              else if (upd_line_rdy_i) st_q[i] <= LS_READY;
              else if (upd_mq_full_i)  st_q[i] <= LS_WAIT_FREE;
              else begin
                tag_q[i] <= upd_mq_tag_i;
                // line may land in the same cycle the tag is learned
                st_q[i]  <= (fill_valid_i && fill_tag_i == upd_mq_tag_i) ? LS_READY : LS_WAIT_TAG;
              end
            end
          end
          LS_WAIT_TAG:  if (wake_tag)  st_q[i] <= LS_READY;
          LS_WAIT_FREE: if (mq_free_i) st_q[i] <= LS_READY;
          LS_READY:     if (rpl_me)    st_q[i] <= LS_EXEC;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rpl_idx_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (gnt[i]) rpl_idx_o = IDX_W'(i);
    end
  end

  assign rpl_valid_o   = |gnt;
  assign rpl_addr_o    = addr_q[rpl_idx_o];
  assign rpl_size_o    = size_q[rpl_idx_o];
  assign rpl_uns_o     = uns_q[rpl_idx_o];
  assign rpl_rob_o     = rob_q[rpl_idx_o];
  assign ret_misspec_o = ret_valid_i && valid_q[ret_idx_i] && mis_q[ret_idx_i];
endmodule

// File: rtl/ld_queue_chk.sv
module ld_queue_chk #(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             alloc_valid_i,
  input logic             alloc_ready_o,
  input logic [IDX_W-1:0] alloc_idx_o,
  input logic             ret_valid_i,
  input logic [IDX_W-1:0] ret_idx_i,
  input logic             rpl_valid_o,
  input logic [IDX_W-1:0] rpl_idx_o,
  input logic [DEPTH-1:0] valid_q,
  input logic [DEPTH-1:0] gnt
);
  logic take;
  assign take = alloc_valid_i && alloc_ready_o && !flush_i;

  AST_ALLOC_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> valid_q[$past(alloc_idx_o)]); // R1

  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> valid_q == '0); // R9

  AST_ONE_REPLAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt)); // R6

  AST_REPLAY_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpl_valid_o |-> valid_q[rpl_idx_o]); // R6

  AST_RETIRE_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i && !(take && alloc_idx_o == ret_idx_i) |=> !valid_q[$past(ret_idx_i)]); // R8
endmodule

bind ld_queue ld_queue_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .flush_i       (flush_i),
  .alloc_valid_i (alloc_valid_i),
  .alloc_ready_o (alloc_ready_o),
  .alloc_idx_o   (alloc_idx_o),
  .ret_valid_i   (ret_valid_i),
  .ret_idx_i     (ret_idx_i),
  .rpl_valid_o   (rpl_valid_o),
  .rpl_idx_o     (rpl_idx_o),
  .valid_q       (valid_q),
  .gnt           (gnt)
);

// File: tb/ld_queue_bench.sv
module ld_queue_bench;
  localparam int DEPTH = 4, ADDR_W = 16, ROB_W = 4, MQ_W = 2, IDX_W = 2;

  logic clk = 1'b0, rst_ni = 1'b0, flush_i = 1'b0;
  logic alloc_valid_i = 1'b0, alloc_uns_i = 1'b0, alloc_ready_o;
  logic [ADDR_W-1:0] alloc_addr_i = '0;
  logic [1:0] alloc_size_i = '0;
  logic [ROB_W-1:0] alloc_rob_i = '0;
  logic [IDX_W-1:0] alloc_idx_o;
  logic upd_valid_i = 1'b0, upd_hit_i = 1'b0, upd_mq_full_i = 1'b0, upd_line_rdy_i = 1'b0;
  logic [IDX_W-1:0] upd_idx_i = '0;
  logic [MQ_W-1:0] upd_mq_tag_i = '0, fill_tag_i = '0;
  logic fill_valid_i = 1'b0, mq_free_i = 1'b0;
  logic rpl_valid_o, rpl_ready_i = 1'b0, rpl_uns_o;
  logic [IDX_W-1:0] rpl_idx_o;
  logic [ADDR_W-1:0] rpl_addr_o;
  logic [1:0] rpl_size_o;
  logic [ROB_W-1:0] rpl_rob_o;
  logic st_valid_i = 1'b0;
  logic [ADDR_W-1:0] st_addr_i = '0;
  logic [1:0] st_size_i = '0;
  logic ret_valid_i = 1'b0, ret_misspec_o;
  logic [IDX_W-1:0] ret_idx_i = '0;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ld_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .ROB_W(ROB_W), .MQ_W(MQ_W), .IDX_W(IDX_W)) u_ld_queue (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i),
    .alloc_valid_i(alloc_valid_i), .alloc_addr_i(alloc_addr_i), .alloc_size_i(alloc_size_i),
    .alloc_uns_i(alloc_uns_i), .alloc_rob_i(alloc_rob_i), .alloc_ready_o(alloc_ready_o),
    .alloc_idx_o(alloc_idx_o),
    .upd_valid_i(upd_valid_i), .upd_idx_i(upd_idx_i), .upd_hit_i(upd_hit_i),
    .upd_mq_full_i(upd_mq_full_i), .upd_line_rdy_i(upd_line_rdy_i), .upd_mq_tag_i(upd_mq_tag_i),
    .fill_valid_i(fill_valid_i), .fill_tag_i(fill_tag_i), .mq_free_i(mq_free_i),
    .rpl_valid_o(rpl_valid_o), .rpl_ready_i(rpl_ready_i), .rpl_idx_o(rpl_idx_o),
    .rpl_addr_o(rpl_addr_o), .rpl_size_o(rpl_size_o), .rpl_uns_o(rpl_uns_o), .rpl_rob_o(rpl_rob_o),
    .st_valid_i(st_valid_i), .st_addr_i(st_addr_i), .st_size_i(st_size_i),
    .ret_valid_i(ret_valid_i), .ret_idx_i(ret_idx_i), .ret_misspec_o(ret_misspec_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // advance one edge; land 1 ns after it with pulses cleared
  task automatic step();
    @(posedge clk);
    #1;
    flush_i = 0; alloc_valid_i = 0; upd_valid_i = 0; fill_valid_i = 0;
    mq_free_i = 0; rpl_ready_i = 0; st_valid_i = 0; ret_valid_i = 0;
    upd_hit_i = 0; upd_mq_full_i = 0; upd_line_rdy_i = 0;
  endtask

  task automatic alloc(input logic [ADDR_W-1:0] a, input logic [1:0] sz, input logic [ROB_W-1:0] rob,
                       input logic [IDX_W-1:0] exp_idx);
    alloc_valid_i = 1; alloc_addr_i = a; alloc_size_i = sz; alloc_uns_i = rob[0]; alloc_rob_i = rob;
    #1 chk("R1 alloc slot", 32'(alloc_idx_o), 32'(exp_idx));
    step();
  endtask

  task automatic upd(input logic [IDX_W-1:0] idx, input logic hit, input logic full,
                     input logic rdy, input logic [MQ_W-1:0] tag);
    upd_valid_i = 1; upd_idx_i = idx; upd_hit_i = hit; upd_mq_full_i = full;
    upd_line_rdy_i = rdy; upd_mq_tag_i = tag;
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    #1;
    chk("R1 reset ready", 32'(alloc_ready_o), 1);
    chk("R1 reset slot", 32'(alloc_idx_o), 0);
    chk("R6 reset no replay", 32'(rpl_valid_o), 0);
    step();

    alloc(16'h0100, 2'd2, 4'd1, 2'd0);
    alloc(16'h0104, 2'd1, 4'd2, 2'd1);
    alloc(16'h0108, 2'd0, 4'd3, 2'd2);
    alloc(16'h010C, 2'd2, 4'd4, 2'd3);
    #1 chk("R1 full stalls", 32'(alloc_ready_o), 0);

    upd(2'd0, 1, 0, 0, 2'd0); step();
    upd(2'd1, 0, 0, 0, 2'd2); step();
    upd(2'd2, 0, 1, 0, 2'd0); step();
    upd(2'd3, 0, 0, 0, 2'd1); step();
    #1 chk("R2 R3 R4 no replay yet", 32'(rpl_valid_o), 0);

    fill_valid_i = 1; fill_tag_i = 2'd3; step();
    #1 chk("R3 other tag ignored", 32'(rpl_valid_o), 0);

    fill_valid_i = 1; fill_tag_i = 2'd2; step();
    #1;
    chk("R3 wake valid", 32'(rpl_valid_o), 1);
    chk("R3 wake slot", 32'(rpl_idx_o), 1);
    chk("R6 replay addr", 32'(rpl_addr_o), 32'h0104);
    chk("R6 replay size", 32'(rpl_size_o), 1);
    chk("R6 replay rob", 32'(rpl_rob_o), 2);
    chk("R6 replay uns", 32'(rpl_uns_o), 0);

    mq_free_i = 1; step();
    #1 chk("R6 oldest first", 32'(rpl_idx_o), 1);
    rpl_ready_i = 1; step();
    #1;
    chk("R4 free wake", 32'(rpl_valid_o), 1);
    chk("R4 free wake slot", 32'(rpl_idx_o), 2);
    rpl_ready_i = 1; step();
    #1 chk("R6 accepted leaves", 32'(rpl_valid_o), 0);

    ret_valid_i = 1; ret_idx_i = 2'd0;
    #1 chk("R8 clean retire", 32'(ret_misspec_o), 0);
    step();
    #1;
    chk("R8 slot freed", 32'(alloc_idx_o), 0);
    chk("R2 hit never replays", 32'(rpl_valid_o), 0);

    alloc(16'h0200, 2'd2, 4'd5, 2'd0);
    upd(2'd0, 0, 0, 1, 2'd0); step();
    #1;
    chk("R5 line ready", 32'(rpl_valid_o), 1);
    chk("R5 line ready slot", 32'(rpl_idx_o), 0);

    fill_valid_i = 1; fill_tag_i = 2'd1; step();
    #1;
    chk("R6 age beats index", 32'(rpl_idx_o), 3);
    chk("R6 age addr", 32'(rpl_addr_o), 32'h010C);
    rpl_ready_i = 1; step();

    upd(2'd1, 0, 0, 0, 2'd0); fill_valid_i = 1; fill_tag_i = 2'd0; step();
    #1 chk("R3 same-cycle wake", 32'(rpl_idx_o), 1);

    flush_i = 1; alloc_valid_i = 1; alloc_addr_i = 16'h0300; step();
    #1;
    chk("R9 flush empties", 32'(rpl_valid_o), 0);
    chk("R9 alloc dropped", 32'(alloc_idx_o), 0);
    chk("R9 ready after flush", 32'(alloc_ready_o), 1);

    for (int ls = 0; ls < 3; ls++) begin
      for (int lo = 0; lo < 4; lo += (1 << ls)) begin
        for (int ss = 0; ss < 3; ss++) begin
          for (int so = 0; so < 8; so += (1 << ss)) begin
            int la, sa, ln, sn;
            logic exp_m;
            la = 16'h0400 + lo; sa = 16'h0400 + so;
            ln = 1 << ls; sn = 1 << ss;
            exp_m = (la < sa + sn) && (sa < la + ln);
            flush_i = 1; step();
            alloc(16'(la), 2'(ls), 4'd7, 2'd0);
            st_valid_i = 1; st_addr_i = 16'(sa); st_size_i = 2'(ss); step();
            ret_valid_i = 1; ret_idx_i = 2'd0;
            #1 chk($sformatf("R7 R8 load %0d@%0d store %0d@%0d", ls, lo, ss, so),
                   32'(ret_misspec_o), 32'(exp_m));
            step();
          end
        end
      end
    end

    finish_run();
  end
endmodule